// File: doc/BRIEF.md
# H-Bridge Fixed Off-Time Chopper

This block regulates current in one winding by chopping the four switches of its H-bridge. In the on-phase it enables one diagonal pair: a high-side source switch on one leg and a low-side sink switch on the other leg. A synchronised comparator input reports when the sensed current has reached the threshold. When that trip is accepted, the block turns the bridge off in one of two ways. In slow decay only the source switch opens. In mixed decay both switches open. The off-phase then runs for a fixed number of clock cycles, after which the same diagonal pair is enabled again.

The surrounding step sequencer supplies the phase polarity and the decay selection. Polarity is sampled only at the start of an on-phase. Decay is sampled only at the moment a trip is accepted. After each turn-on, a blanking window ignores the switching spike on the comparator. A disable input, normally tied to system reset, opens every switch at once. After any reversal of polarity, the block inserts one all-off cycle so that no leg ever has its high and low switches conducting together.

Top module: `hbridge_chopper`

## Requirements
- R1: While `rst_n` is low or `disable_i` is high, all four gate enables are low, and `disable_i` acts in the same cycle. After enabling, the block spends one cycle idle and one all-off cycle before the first on-phase, which starts with a full blanking window.
- R2: In the on-phase, polarity 0 drives leg A high and leg B low (gates {a_hi,a_lo,b_hi,b_lo} = 1001). Polarity 1 drives leg B high and leg A low (0110).
- R3: A trip accepted with `decay_mixed_i` = 0 opens only the high-side switch. The low-side switch of the other leg stays on (0001 for polarity 0, 0100 for polarity 1).
- R4: A trip accepted with `decay_mixed_i` = 1 opens both switches, giving 0000 in the off-phase.
- R5: The off-phase lasts exactly OFF_CYCLES clock cycles. The on-phase then restarts.
- R6: Trips are ignored during the off-phase and during the first BLANK_CYCLES cycles of an on-phase. A trip held from the start of an on-phase ends it after exactly BLANK_CYCLES+1 cycles.
- R7: The decay selection is captured in the cycle the trip is accepted. Changing it during the off-phase has no effect on that off-phase.
- R8: A polarity change during an on-phase or off-phase takes effect only at the next on-phase start. If the new polarity differs from the one in use, exactly one all-off cycle precedes the new on-phase.
- R9: No leg ever has both its switches on together. A switch never turns on in the cycle right after the other switch of the same leg was on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| disable_i | input | 1 | Forces all switches off and clears the sequence |
| trip_i | input | 1 | Synchronised comparator output: current at or above threshold |
| polarity_i | input | 1 | Phase polarity: 0 selects A-high/B-low, 1 selects B-high/A-low |
| decay_mixed_i | input | 1 | 1 selects mixed decay, 0 selects slow decay |
| a_hi_o | output | 1 | Leg A high-side enable |
| a_lo_o | output | 1 | Leg A low-side enable |
| b_hi_o | output | 1 | Leg B high-side enable |
| b_lo_o | output | 1 | Leg B low-side enable |

## Verification
Every internal fault in this block shows up at the four gate pins within one off-time plus one blanking window. A wrong counter load lengthens or shortens the run of off-phase vectors, or moves the first cycle in which a trip is acted on. A polarity or decay bit latched at the wrong moment shows up as a wrong diagonal vector, or as a missing or extra all-off cycle, on the very next phase boundary. The bench compares the gate vector in every cycle of sequences that cover both polarities, both decay modes, trips held through the blanking and off windows, and disable asserted in the middle of both phases.

// File: rtl/chop_pkg.sv
package chop_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // disabled, every switch open
    PH_GAP  = 2'd1,  // one all-off cycle before an on-phase
    PH_ON   = 2'd2,  // diagonal pair conducting
    PH_OFF  = 2'd3   // fixed off-time running
  } chop_phase_e;

  // Number of bridge legs driven
  localparam int unsigned NUM_LEGS = 2;

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Next-state logic
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  // Register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

  // R5: an unloaded, non-zero count falls by one each cycle
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R1: a clear always leaves the timer expired
  p_clr_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> done_o);

endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int unsigned OFF_CYCLES   = 32,
  parameter int unsigned BLANK_CYCLES = 4,
  parameter int unsigned CW           = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disable_i,
  input  logic          trip_i,
  input  logic          polarity_i,
  input  logic          decay_mixed_i,
  input  logic          tmr_done_i,
  output logic          tmr_clr_o,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output chop_phase_e   phase_o,
  output logic          pol_o,
  output logic          mixed_o
);

  localparam logic [CW-1:0] BLANK_LD = CW'(BLANK_CYCLES);
  localparam logic [CW-1:0] OFF_LD   = CW'(OFF_CYCLES - 1);

  chop_phase_e phase_q, phase_d;
  logic        pol_q, pol_d;
  logic        mix_q, mix_d;
  logic        trip_ok;

  // A trip counts only in the on-phase after blanking has expired
  assign trip_ok = (phase_q == PH_ON) && tmr_done_i && trip_i;

  // Next-state logic
  always_comb begin
    phase_d    = phase_q;
    pol_d      = pol_q;
    mix_d      = mix_q;
    tmr_clr_o  = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = BLANK_LD;
    if (disable_i) begin
      phase_d   = PH_IDLE;
      tmr_clr_o = 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: phase_d = PH_GAP;
        PH_GAP: begin
          phase_d    = PH_ON;
          pol_d      = polarity_i;
          tmr_load_o = 1'b1;
          tmr_val_o  = BLANK_LD;
        end
        PH_ON: begin
          if (trip_ok) begin
            phase_d    = PH_OFF;
            mix_d      = decay_mixed_i;
            tmr_load_o = 1'b1;
            tmr_val_o  = OFF_LD;
          end
        end
        PH_OFF: begin
          if (tmr_done_i) begin
            if (polarity_i == pol_q) begin
              phase_d    = PH_ON;
              tmr_load_o = 1'b1;
              tmr_val_o  = BLANK_LD;
            end else begin
              phase_d = PH_GAP;
            end
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pol_q   <= 1'b0;
      mix_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pol_q   <= pol_d;
      mix_q   <= mix_d;
    end
  end

  assign phase_o = phase_q;
  assign pol_o   = pol_q;
  assign mixed_o = mix_q;

  // R6: inside the blanking window the on-phase continues whatever the comparator says
  p_blank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ON && !tmr_done_i && !disable_i) |=> (phase_q == PH_ON));

  // R6: a trip after blanking ends the on-phase on the next edge
  p_trip_turnoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ON && tmr_done_i && trip_i && !disable_i) |=> (phase_q == PH_OFF));

  // R8: the polarity in use never changes inside an on-phase
  p_pol_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ON && $past(phase_q) == PH_ON) |-> $stable(pol_q));

  // R7: the decay choice is frozen through the off-phase
  p_mix_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OFF && $past(phase_q) == PH_OFF) |-> $stable(mix_q));

  // R8: the all-off gap lasts one cycle only
  p_gap_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_GAP) |=> (phase_q != PH_GAP));

  // R1: disable always returns the sequencer to idle
  p_disable_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
  import chop_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                disable_i,
  input  chop_phase_e         phase_i,
  input  logic                pol_i,
  input  logic                mixed_i,
  output logic [NUM_LEGS-1:0] hi_o,
  output logic [NUM_LEGS-1:0] lo_o
);

  logic on_ph;
  logic sink_kept;

  assign on_ph     = (phase_i == PH_ON);
  assign sink_kept = on_ph || ((phase_i == PH_OFF) && !mixed_i);

  // Leg 0 sources current for polarity 0, leg 1 for polarity 1
  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    localparam logic LEG_ID = 1'(l);
    logic is_src;
    assign is_src  = (pol_i == LEG_ID);
    assign hi_o[l] = !disable_i && on_ph && is_src;
    assign lo_o[l] = !disable_i && sink_kept && !is_src;

    // R9: one leg never conducts through both switches
    p_no_shoot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_o[l] && lo_o[l]));

    // R9: break-before-make, low to high
    p_bbm_lo_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lo_o[l]) |-> !hi_o[l]);

    // R9: break-before-make, high to low
    p_bbm_hi_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hi_o[l]) |-> !lo_o[l]);
  end

  // R1: disable opens every switch in the same cycle
  p_dis_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |-> (hi_o == '0 && lo_o == '0));

  // R4: a mixed off-phase leaves no switch closed
  p_mixed_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_OFF && mixed_i) |-> (hi_o == '0 && lo_o == '0));

endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
  import chop_pkg::*;
#(
  parameter int unsigned OFF_CYCLES   = 32,
  parameter int unsigned BLANK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic disable_i,
  input  logic trip_i,
  input  logic polarity_i,
  input  logic decay_mixed_i,
  output logic a_hi_o,
  output logic a_lo_o,
  output logic b_hi_o,
  output logic b_lo_o
);

  localparam int unsigned TOP_CNT = (OFF_CYCLES > BLANK_CYCLES) ? OFF_CYCLES : BLANK_CYCLES;
  localparam int unsigned CW      = $clog2(TOP_CNT + 1);

  logic                tmr_clr;
  logic                tmr_load;
  logic [CW-1:0]       tmr_val;
  logic                tmr_done;
  chop_phase_e         phase;
  logic                pol;
  logic                mixed;
  logic [NUM_LEGS-1:0] hi;
  logic [NUM_LEGS-1:0] lo;

  chop_timer #(
    .CW (CW)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (tmr_clr),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  chop_seq #(
    .OFF_CYCLES   (OFF_CYCLES),
    .BLANK_CYCLES (BLANK_CYCLES),
    .CW           (CW)
  ) seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .disable_i     (disable_i),
    .trip_i        (trip_i),
    .polarity_i    (polarity_i),
    .decay_mixed_i (decay_mixed_i),
    .tmr_done_i    (tmr_done),
    .tmr_clr_o     (tmr_clr),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .phase_o       (phase),
    .pol_o         (pol),
    .mixed_o       (mixed)
  );

  chop_gate_map map_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .disable_i (disable_i),
    .phase_i   (phase),
    .pol_i     (pol),
    .mixed_i   (mixed),
    .hi_o      (hi),
    .lo_o      (lo)
  );

  assign a_hi_o = hi[0];
  assign a_lo_o = lo[0];
  assign b_hi_o = hi[1];
  assign b_lo_o = lo[1];

  // R3: a slow off-phase keeps exactly one switch, a low side, closed
  p_slow_sink_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OFF && !mixed && !disable_i) |->
      (!a_hi_o && !b_hi_o && $countones({a_lo_o, b_lo_o}) == 1));

  // R2: an on-phase always has exactly one source and one sink
  p_diag_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ON && !disable_i) |->
      ($onehot0({a_hi_o, b_hi_o}) && $countones({a_hi_o, b_hi_o, a_lo_o, b_lo_o}) == 2));

endmodule

// File: tb/hbridge_chopper_tb.sv
module hbridge_chopper_tb_top;

  localparam int unsigned OFF_N   = 5;
  localparam int unsigned BLANK_N = 2;

  localparam logic [3:0] P0 = 4'b1001;  // polarity 0 on-phase
  localparam logic [3:0] P1 = 4'b0110;  // polarity 1 on-phase
  localparam logic [3:0] S0 = 4'b0001;  // slow off, polarity 0
  localparam logic [3:0] S1 = 4'b0100;  // slow off, polarity 1
  localparam logic [3:0] Z  = 4'b0000;  // all open

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic dis, trip, pol, mix;
  logic a_hi, a_lo, b_hi, b_lo;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hbridge_chopper #(
    .OFF_CYCLES   (OFF_N),
    .BLANK_CYCLES (BLANK_N)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .disable_i     (dis),
    .trip_i        (trip),
    .polarity_i    (pol),
    .decay_mixed_i (mix),
    .a_hi_o        (a_hi),
    .a_lo_o        (a_lo),
    .b_hi_o        (b_hi),
    .b_lo_o        (b_lo)
  );

  // Monitor: compare the gate vector at each falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if ({a_hi, a_lo, b_hi, b_lo} !== it.exp) begin
        errors++;
        $display("FAIL %s: gates actual %b expected %b at %0t",
                 it.tag, {a_hi, a_lo, b_hi, b_lo}, it.exp, $time);
      end
    end
  end

  // Driver: set inputs just after an edge, queue the vector expected in this cycle
  task automatic drive(input logic t, input logic p, input logic m, input logic d,
                       input logic [3:0] e, input string tag);
    @(posedge clk);
    #1;
    trip = t; pol = p; mix = m; dis = d;
    exp_q.push_back('{exp: e, tag: tag});
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; dis = 1'b0; trip = 1'b0; pol = 1'b0; mix = 1'b0;
    // R1: reset holds every switch open
    drive(0, 0, 0, 0, Z, "R1");
    drive(0, 0, 0, 0, Z, "R1");
    @(posedge clk); #1; rst_n = 1'b1;
    exp_q.push_back('{exp: Z, tag: "R1"});          // idle
    drive(0, 0, 0, 0, Z, "R1");                     // gap before first on-phase
    // R2 polarity 0, trip held: R6 blanking gives BLANK_N+1 on cycles
    drive(1, 0, 0, 0, P0, "R2");
    repeat (BLANK_N) drive(1, 0, 0, 0, P0, "R6");
    // R3 slow off keeps B low; R7 decay change mid off-phase ignored
    drive(1, 0, 0, 0, S0, "R3");
    drive(1, 0, 1, 0, S0, "R7");
    repeat (OFF_N - 2) drive(1, 0, 1, 0, S0, "R5");
    // R5 restart after exactly OFF_N cycles, trips during off ignored
    drive(1, 0, 1, 0, P0, "R5");
    repeat (BLANK_N) drive(1, 0, 1, 0, P0, "R6");
    // R4 mixed off, R8 polarity flips during off
    drive(1, 0, 1, 0, Z, "R4");
    drive(1, 1, 1, 0, Z, "R8");
    repeat (OFF_N - 2) drive(1, 1, 1, 0, Z, "R5");
    drive(0, 1, 1, 0, Z, "R9");                     // one gap cycle on reversal
    drive(0, 1, 1, 0, P1, "R2");
    // R8 polarity change inside on-phase has no effect
    repeat (5) drive(0, 0, 1, 0, P1, "R8");
    drive(1, 0, 0, 0, P1, "R2");
    // R3 slow off with polarity 1 keeps A low
    drive(1, 0, 0, 0, S1, "R3");
    repeat (OFF_N - 1) drive(1, 0, 0, 0, S1, "R5");
    // R9 A low was on: gap before A high
    drive(0, 0, 0, 0, Z, "R9");
    drive(0, 0, 0, 0, P0, "R8");
    drive(0, 0, 0, 0, P0, "R2");
    // R1 disable in on-phase acts in the same cycle
    drive(0, 0, 0, 1, Z, "R1");
    drive(0, 0, 0, 1, Z, "R1");
    drive(0, 0, 0, 0, Z, "R1");
    drive(0, 0, 0, 0, Z, "R1");
    drive(1, 0, 0, 0, P0, "R6");
    repeat (BLANK_N) drive(1, 0, 0, 0, P0, "R6");
    drive(1, 0, 0, 0, S0, "R3");
    // R1 disable in off-phase clears the off-time
    drive(1, 0, 0, 1, Z, "R1");
    drive(1, 0, 0, 1, Z, "R1");
    drive(1, 0, 0, 0, Z, "R1");
    drive(1, 0, 0, 0, Z, "R1");
    drive(1, 0, 0, 0, P0, "R6");
    repeat (BLANK_N) drive(1, 0, 0, 0, P0, "R6");
    drive(1, 0, 0, 0, S0, "R3");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    finish_run();
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule